// File: doc/BRIEF.md
# Latched Byte Shifter

This block holds incoming bytes in a small circular queue and sends them one at a time to an external serial-in, parallel-out shift register. It drives a serial data line and a shift clock. A consumer on the far side reads the parallel outputs of the register. An external set/reset latch tells the block when that consumer is ready for another byte. The consumer sets the latch once it has read the current byte. After the block has clocked out all eight bits, it pulses the latch reset output. This clears the latch, which tells the consumer that a fresh byte is waiting and stops the next transfer until the consumer is ready again.

The serial data line is shared with another function, so the block drives it only while a byte is being shifted. It raises a drive-enable output for exactly that window. No transfer starts while a neighbouring transmitter reports that it is busy. Bytes that arrive while the queue is full are discarded, and a sticky overflow flag records that this happened.

Top module: `latched_byte_shifter`

## Requirements
- R1: After reset, `sclk_o` is high, and `sdata_o`, `data_oe_o`, `latch_rst_o` and `overflow_o` are low.
- R2: Bytes are sent in the order they were accepted. The queue is empty when its read and write positions are equal. Both positions wrap to slot zero after slot DEPTH-1, so order holds across many more than DEPTH bytes.
- R3: A transfer starts only when the queue is not empty and `latch_ready_i` is high. While `latch_ready_i` is low, queued bytes wait and `sclk_o` does not toggle.
- R4: A transfer does not start while `tx_busy_i` is high, even when a byte is queued and the latch is ready.
- R5: Each byte produces exactly eight rising edges of `sclk_o`, most significant bit first. `sdata_o` changes only when `sclk_o` falls and is stable at each rising edge.
- R6: During a transfer, each low phase and each high phase between bits lasts PHASE_CYCLES system clocks.
- R7: `data_oe_o` is high for the whole transfer and is high at every rising edge of `sclk_o`. It is low while idle and during the latch reset pulse.
- R8: After the eighth high phase, `latch_rst_o` goes high for PHASE_CYCLES system clocks with `sclk_o` high, then returns low. There is one pulse per byte.
- R9: A byte offered (`in_valid_i` high) while DEPTH bytes are queued is dropped. `overflow_o` then goes high and stays high until reset. A queue filled to exactly DEPTH does not raise it, and bytes already queued are sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | A new byte is offered this cycle |
| in_byte_i | input | 8 | Byte offered for queuing |
| latch_ready_i | input | 1 | Latch output: consumer has taken the previous byte |
| tx_busy_i | input | 1 | Neighbouring transmitter owns the shared lines |
| sdata_o | output | 1 | Serial data to the shift register |
| sclk_o | output | 1 | Shift clock; the register samples on its rising edge |
| latch_rst_o | output | 1 | Pulse that clears the handshake latch |
| data_oe_o | output | 1 | Drive enable for the shared data line |
| overflow_o | output | 1 | Sticky flag: a byte was dropped because the queue was full |

## Verification
The bench holds the latch low with a byte queued and checks that the clock never moves. A block that ignored the ready level would shift over a byte the consumer had not yet read. It does the same with the transmitter busy, where a faulty block would collide on the shared line. It fills the queue to exactly DEPTH and then a few more, and checks that the flag rises only on the first extra byte and that the kept bytes come out intact. An off-by-one full test would either lose the last slot or corrupt the oldest byte. Long random runs pass many times DEPTH bytes through with random re-arm delays, and each bit and each phase width is checked. This catches pointer wrap errors, LSB-first ordering, a ninth or missing clock edge, and a latch pulse that is too short or comes too early.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef logic [7:0] lbs_byte_t;

    typedef enum logic [1:0] {
        LBS_IDLE  = 2'd0,
        LBS_LOW   = 2'd1,
        LBS_HIGH  = 2'd2,
        LBS_PULSE = 2'd3
    } lbs_state_e;

endpackage

// File: rtl/lbs_queue.sv
module lbs_queue
    import lbs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  lbs_byte_t data_i,
    input  logic      pop_i,
    output lbs_byte_t head_o,
    output logic      empty_o,
    output logic      ovf_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wr_idx;
        logic                  wr_lap;
        logic [AW-1:0]         rd_idx;
        logic                  rd_lap;
        logic                  ovf;
    } q_state_t;

    q_state_t q_q, q_d;

    logic is_empty;
    logic is_full;

    function automatic logic [AW-1:0] step_idx(input logic [AW-1:0] idx);
        return (idx == LAST_IDX) ? '0 : idx + 1'b1;
    endfunction

    always_comb begin
        is_empty = (q_q.wr_idx == q_q.rd_idx) && (q_q.wr_lap == q_q.rd_lap);
        is_full  = (q_q.wr_idx == q_q.rd_idx) && (q_q.wr_lap != q_q.rd_lap);

        q_d = q_q;

        if (push_i && !is_full) begin
            q_d.mem[q_q.wr_idx] = data_i;
            q_d.wr_idx          = step_idx(q_q.wr_idx);
            if (q_q.wr_idx == LAST_IDX) begin
                q_d.wr_lap = ~q_q.wr_lap;
            end
        end

        if (push_i && is_full) begin
            q_d.ovf = 1'b1;
        end

        if (pop_i && !is_empty) begin
            q_d.rd_idx = step_idx(q_q.rd_idx);
            if (q_q.rd_idx == LAST_IDX) begin
                q_d.rd_lap = ~q_q.rd_lap;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head_o  = q_q.mem[q_q.rd_idx];
    assign empty_o = is_empty;
    assign ovf_o   = q_q.ovf;

endmodule

// File: rtl/lbs_serializer.sv
module lbs_serializer
    import lbs_pkg::*;
#(
    parameter int PHASE_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      empty_i,
    input  lbs_byte_t head_i,
    input  logic      ready_i,
    input  logic      busy_i,
    output logic      pop_o,
    output logic      sdata_o,
    output logic      sclk_o,
    output logic      oe_o,
    output logic      lrst_o
);

    localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CW-1:0] PH_LAST = CW'(PHASE_CYCLES - 1);

    typedef struct packed {
        lbs_state_e    st;
        logic [CW-1:0] ph;
        logic [2:0]    bit_n;
        lbs_byte_t     sh;
        logic          sclk;
        logic          sdat;
        logic          oe;
        logic          lrst;
    } ser_state_t;

    localparam ser_state_t SER_RST = '{
        st: LBS_IDLE, ph: '0, bit_n: '0, sh: '0,
        sclk: 1'b1, sdat: 1'b0, oe: 1'b0, lrst: 1'b0
    };

    ser_state_t s_q, s_d;
    logic       start;

    always_comb begin
        s_d   = s_q;
        start = 1'b0;

        unique case (s_q.st)
            LBS_IDLE: begin
                if (!empty_i && ready_i && !busy_i) begin
                    start    = 1'b1;
                    s_d.st   = LBS_LOW;
                    s_d.sh   = head_i;
                    s_d.sdat = head_i[7];
                    s_d.sclk = 1'b0;
                    s_d.oe   = 1'b1;
                    s_d.ph   = '0;
                    s_d.bit_n = '0;
                end
            end
            LBS_LOW: begin
                if (s_q.ph == PH_LAST) begin
                    s_d.st   = LBS_HIGH;
                    s_d.sclk = 1'b1;
                    s_d.ph   = '0;
                end else begin
                    s_d.ph = s_q.ph + 1'b1;
                end
            end
            LBS_HIGH: begin
                if (s_q.ph != PH_LAST) begin
                    s_d.ph = s_q.ph + 1'b1;
                end else if (s_q.bit_n == 3'd7) begin
                    s_d.st   = LBS_PULSE;
                    s_d.oe   = 1'b0;
                    s_d.sdat = 1'b0;
                    s_d.lrst = 1'b1;
                    s_d.ph   = '0;
                end else begin
                    s_d.st    = LBS_LOW;
                    s_d.sh    = s_q.sh << 1;
                    s_d.sdat  = s_q.sh[6];
                    s_d.sclk  = 1'b0;
                    s_d.bit_n = s_q.bit_n + 3'd1;
                    s_d.ph    = '0;
                end
            end
            LBS_PULSE: begin
                if (s_q.ph == PH_LAST) begin
                    s_d.st   = LBS_IDLE;
                    s_d.lrst = 1'b0;
                    s_d.ph   = '0;
                end else begin
                    s_d.ph = s_q.ph + 1'b1;
                end
            end
            default: s_d = SER_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SER_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign pop_o   = start;
    assign sdata_o = s_q.sdat;
    assign sclk_o  = s_q.sclk;
    assign oe_o    = s_q.oe;
    assign lrst_o  = s_q.lrst;

endmodule

// File: rtl/latched_byte_shifter.sv
module latched_byte_shifter
    import lbs_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int PHASE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid_i,
    input  logic [7:0] in_byte_i,
    input  logic       latch_ready_i,
    input  logic       tx_busy_i,
    output logic       sdata_o,
    output logic       sclk_o,
    output logic       latch_rst_o,
    output logic       data_oe_o,
    output logic       overflow_o
);

    lbs_byte_t head;
    logic      q_empty;
    logic      pop;

    lbs_queue #(
        .DEPTH (DEPTH)
    ) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (in_valid_i),
        .data_i  (in_byte_i),
        .pop_i   (pop),
        .head_o  (head),
        .empty_o (q_empty),
        .ovf_o   (overflow_o)
    );

    lbs_serializer #(
        .PHASE_CYCLES (PHASE_CYCLES)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .empty_i (q_empty),
        .head_i  (head),
        .ready_i (latch_ready_i),
        .busy_i  (tx_busy_i),
        .pop_o   (pop),
        .sdata_o (sdata_o),
        .sclk_o  (sclk_o),
        .oe_o    (data_oe_o),
        .lrst_o  (latch_rst_o)
    );

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker (
    input logic clk,
    input logic rst_n,
    input logic latch_ready_i,
    input logic tx_busy_i,
    input logic sdata_o,
    input logic sclk_o,
    input logic latch_rst_o,
    input logic data_oe_o,
    input logic overflow_o
);

    AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> $past(latch_ready_i)); // R3

    AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> !$past(tx_busy_i)); // R4

    AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdata_o)); // R5

    AST_LOW_CLOCK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_o |-> data_oe_o); // R7

    AST_PULSE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rst_o |-> !data_oe_o); // R7

    AST_PULSE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_rst_o) |-> ($past(data_oe_o) && $past(sclk_o))); // R8

    AST_PULSE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rst_o |-> sclk_o); // R8

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R9

endmodule

bind latched_byte_shifter lbs_checker u_lbs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .latch_ready_i (latch_ready_i),
    .tx_busy_i     (tx_busy_i),
    .sdata_o       (sdata_o),
    .sclk_o        (sclk_o),
    .latch_rst_o   (latch_rst_o),
    .data_oe_o     (data_oe_o),
    .overflow_o    (overflow_o)
);

// File: tb/latched_byte_shifter_bench.sv
module latched_byte_shifter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int PHASE      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       tx_busy = 1'b0;
    logic       latch_q = 1'b1;
    logic       hold_latch = 1'b0;
    logic       latch_ready;
    logic       sdata, sclk, lrst, oe, ovf;

    int checks = 0;
    int errors = 0;
    int fall_cnt = 0;
    int rx_cnt = 0;
    int push_cnt = 0;
    logic [7:0] exp_q[$];
    logic done = 1'b0;

    assign latch_ready = latch_q && !hold_latch;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_byte_shifter #(
        .DEPTH        (DEPTH),
        .PHASE_CYCLES (PHASE)
    ) u_latched_byte_shifter (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid_i    (in_valid),
        .in_byte_i     (in_byte),
        .latch_ready_i (latch_ready),
        .tx_busy_i     (tx_busy),
        .sdata_o       (sdata),
        .sclk_o        (sclk),
        .latch_rst_o   (lrst),
        .data_oe_o     (oe),
        .overflow_o    (ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [7:0] b, input int idx);
        return b[7 - idx];
    endfunction

    // Monitor: models the shift register and the handshake latch
    logic       prev_sclk = 1'b1;
    logic       prev_lrst = 1'b0;
    int         run = 0;
    int         lrst_run = 0;
    int         bit_idx = 0;
    int         rearm = 0;
    logic [7:0] cap = 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk != prev_sclk) begin
                if (!sclk) begin
                    fall_cnt++;
                    if (bit_idx > 0) chk(run == PHASE, "R6 high phase width", run, PHASE);
                end else begin
                    chk(run == PHASE, "R6 low phase width", run, PHASE);
                    chk(oe == 1'b1, "R7 drive at rising edge", oe, 1);
                    if (exp_q.size() > 0)
                        chk(sdata == exp_bit(exp_q[0], bit_idx), "R5 bit value msb first",
                            sdata, exp_bit(exp_q[0], bit_idx));
                    else
                        chk(1'b0, "R2 shift with nothing expected", bit_idx, 0);
                    cap = {cap[6:0], sdata};
                    bit_idx++;
                end
                run = 1;
            end else begin
                run++;
            end
            if (lrst) begin
                lrst_run++;
                latch_q = 1'b0;
                chk(oe == 1'b0, "R7 released during pulse", oe, 0);
            end
            if (prev_lrst && !lrst) begin
                chk(lrst_run == PHASE, "R8 pulse width", lrst_run, PHASE);
                chk(bit_idx == 8, "R8 pulse after eighth bit", bit_idx, 8);
                if (exp_q.size() > 0) begin
                    chk(cap == exp_q[0], "R2 byte order", cap, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                rx_cnt++;
                bit_idx = 0;
                lrst_run = 0;
                rearm = 1 + int'($urandom % 20);
            end else if (!lrst && rearm > 0) begin
                rearm--;
                if (rearm == 0) latch_q = 1'b1;
            end
            prev_sclk = sclk;
            prev_lrst = lrst;
        end
    end

    task automatic push(input logic [7:0] b, input bit expect_kept);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        if (expect_kept) begin
            exp_q.push_back(b);
            push_cnt++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !lrst && sclk && !oe && rearm == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int f0;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sclk == 1'b1, "R1 sclk idle high", sclk, 1);
        chk(sdata == 1'b0, "R1 sdata low", sdata, 0);
        chk(oe == 1'b0, "R1 drive off", oe, 0);
        chk(lrst == 1'b0, "R1 pulse low", lrst, 0);
        chk(ovf == 1'b0, "R1 overflow clear", ovf, 0);

        // R3: latch not ready holds the byte; R4: busy transmitter holds it
        hold_latch = 1'b1;
        tx_busy    = 1'b1;
        f0 = fall_cnt;
        push(8'hA5, 1'b1);
        repeat (100) @(negedge clk);
        chk(fall_cnt == f0, "R3 no shift while latch low", fall_cnt - f0, 0);
        hold_latch = 1'b0;
        repeat (100) @(negedge clk);
        chk(fall_cnt == f0, "R4 no shift while busy", fall_cnt - f0, 0);
        tx_busy = 1'b0;
        wait_drain();
        chk(fall_cnt - f0 == 8, "R5 eight clocks per byte", fall_cnt - f0, 8);

        // Directed patterns
        push(8'h00, 1'b1);
        push(8'hFF, 1'b1);
        push(8'h80, 1'b1);
        push(8'h01, 1'b1);
        wait_drain();

        // R9: fill to exactly DEPTH, then overflow
        hold_latch = 1'b1;
        for (int i = 0; i < DEPTH; i++) push(8'(8'h10 + i), 1'b1);
        @(negedge clk);
        chk(ovf == 1'b0, "R9 exactly full no overflow", ovf, 0);
        for (int i = 0; i < 3; i++) push(8'(8'hE0 + i), 1'b0);
        @(negedge clk);
        chk(ovf == 1'b1, "R9 overflow raised", ovf, 1);
        hold_latch = 1'b0;
        wait_drain();
        chk(ovf == 1'b1, "R9 overflow sticky", ovf, 1);

        // Random traffic across many pointer wraps (R2)
        for (int it = 0; it < 120; it++) begin
            tx_busy = ($urandom % 4) == 0;
            if (exp_q.size() < DEPTH - 1) push(8'($urandom), 1'b1);
            repeat ($urandom % 30) @(negedge clk);
        end
        tx_busy = 1'b0;
        wait_drain();
        chk(rx_cnt == push_cnt, "R2 every kept byte delivered", rx_cnt, push_cnt);
        chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

        done = 1'b1;
        finish_run();
    end

endmodule